// File: doc/BRIEF.md
# Ethernet-to-PON Upstream Segmenter

This block sits between a nibble-wide Ethernet receive interface and a 16-bit serializer feeding a passive optical network uplink. Nibbles arrive one per accepted cycle and are assembled into bytes. The bytes are collected in a segment store. When the store holds a full payload, or when the frame ends, the block emits one fixed-length upstream packet. The packet is a six-word header followed by the payload, zero-padded to a constant length.

The header starts with a sync word. It then carries the unit identifier of the sender, a flag byte whose bit 0 marks the final segment of a frame, and the true payload byte count. Long frames are cut into consecutive full segments. Only the last segment of a frame carries the end-of-frame mark. Input and output share one clock, and both sides use a valid strobe. The input side also has a ready signal that holds off the source while a packet is being sent.

Top module: `pon_up_segmenter`

## Requirements
- R1: After reset, rx_ready is 1 and tx_valid is 0.
- R2: Nibbles are taken low half first: the first accepted nibble of a pair is byte bits [3:0] and the second is bits [7:4]. Payload bytes are packed two per word with the earlier byte in tx_data[15:8].
- R3: Each packet is 140 words on consecutive cycles with tx_valid high. Word 0 is 16'hA55A. Word 1 is {unit_id[7:0], flags[7:0]}. Word 2 is the payload byte count. Words 3 to 5 are zero. Words 6 to 139 carry the payload.
- R4: A frame of N bytes yields ceil(N/268) packets in order. Every packet except the last carries 268 payload bytes and a length field of 268.
- R5: Flag bit 0 (end of frame) is 1 in the last packet of a frame and 0 in every earlier packet. The other flag bits are 0.
- R6: In a final segment shorter than 268 bytes, every payload byte at or beyond the length field is zero, and the length field holds the true byte count.
- R7: If a frame ends on the low nibble of a byte, that byte is completed with a zero upper nibble and counted in the length. A frame with an odd byte count has a zero low byte in its last payload word.
- R8: rx_ready is 0 from the cycle after a segment closes until the last word of its packet has been sent. Nibbles offered while rx_ready is 0, including their last marks, are ignored.
- R9: A frame of exactly 268 bytes produces one packet with length 268 and the end-of-frame bit set.
- R10: unit_id is sampled when a segment closes, and that value appears in the header of that segment's packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| unit_id | input | 8 | Identifier of this network unit |
| rx_valid | input | 1 | Nibble offered |
| rx_nibble | input | 4 | Receive nibble |
| rx_last | input | 1 | Offered nibble is the last of its frame |
| rx_ready | output | 1 | Block can accept a nibble this cycle |
| tx_valid | output | 1 | tx_data holds a packet word |
| tx_data | output | 16 | Packet word toward the serializer |

## Verification
The hardest situation to reach is a source that keeps pushing while a packet drains. A stale byte or a stray last mark must then not leak into the next segment. It is also hard to make a segment close exactly on the store boundary at the same moment the frame ends. The driver always offers a nibble, and while rx_ready is low it offers 4'hF with the last mark set. Frame lengths are picked on either side of 268 and 536 bytes, and some frames end on an odd nibble. This forces both the full-store close and the end-of-frame close, and every byte of every packet is compared against a model built from the requirements.

// File: rtl/pon_seg_pkg.sv
package pon_seg_pkg;
    typedef enum logic {
        ST_FILL = 1'b0,
        ST_SEND = 1'b1
    } seg_state_e;
endpackage

// File: rtl/pon_nib_pack.sv
module pon_nib_pack (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc,
    input  logic [3:0] nib,
    input  logic       nib_last,
    output logic       byte_vld,
    output logic [7:0] byte_dat,
    output logic       byte_last
);
    typedef struct packed {
        logic       phase;
        logic [3:0] lo;
    } pack_t;

    pack_t r_q, r_d;

    always_comb begin
        r_d       = r_q;
        byte_vld  = acc && (r_q.phase || nib_last);
        byte_dat  = r_q.phase ? {nib, r_q.lo} : {4'h0, nib};
        byte_last = nib_last;
        if (acc) begin
            if (byte_vld) begin
                r_d.phase = 1'b0;
            end else begin
                r_d.phase = 1'b1;
                r_d.lo    = nib;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R2: a non-final accepted nibble flips the half-byte phase
    a_r2_phase_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !nib_last) |=> (r_q.phase != $past(r_q.phase)));
    // R7: a frame end always leaves the assembler at a byte boundary
    a_r7_end_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && nib_last) |=> !r_q.phase);
endmodule

// File: rtl/pon_seg_store.sv
module pon_seg_store #(
    parameter int DEPTH = 268,
    parameter int AW    = 9
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_hi,
    output logic [7:0]    rd_lo
);
    logic [7:0] mem [DEPTH];
    logic [AW:0] rd_next;

    always_ff @(posedge clk) begin
        if (wr_en && (int'(wr_addr) < DEPTH)) mem[wr_addr] <= wr_data;
    end

    always_comb begin
        rd_next = {1'b0, rd_addr} + 1'b1;
        rd_hi   = (int'(rd_addr) < DEPTH) ? mem[rd_addr] : 8'h00;
        rd_lo   = (int'(rd_next) < DEPTH) ? mem[rd_next[AW-1:0]] : 8'h00;
    end
endmodule

// File: rtl/pon_pkt_word.sv
module pon_pkt_word #(
    parameter int HDR_WORDS = 6,
    parameter int IDX_W     = 8,
    parameter int LEN_W     = 9,
    parameter logic [15:0] SYNC_WORD = 16'hA55A
) (
    input  logic [IDX_W-1:0] widx,
    input  logic [7:0]       id,
    input  logic             eof,
    input  logic [LEN_W-1:0] len,
    input  logic [7:0]       pay_hi,
    input  logic [7:0]       pay_lo,
    output logic [15:0]      word
);
    logic [15:0] hdr [HDR_WORDS];
    int unsigned off;

    generate
        for (genvar g = 0; g < HDR_WORDS; g++) begin : g_hdr
            if (g == 0)      begin : g_sync  assign hdr[g] = SYNC_WORD; end
            else if (g == 1) begin : g_ident assign hdr[g] = {id, 7'b0, eof}; end
            else if (g == 2) begin : g_len   assign hdr[g] = 16'(len); end
            else             begin : g_rsv   assign hdr[g] = 16'h0000; end
        end
    endgenerate

    always_comb begin
        off  = 2 * (int'(widx) - HDR_WORDS);
        word = 16'h0000;
        if (int'(widx) < HDR_WORDS) begin
            word = hdr[widx[$clog2(HDR_WORDS)-1:0]];
        end else begin
            word[15:8] = (off < int'(len))     ? pay_hi : 8'h00;
            word[7:0]  = (off + 1 < int'(len)) ? pay_lo : 8'h00;
        end
    end
endmodule

// File: rtl/pon_up_segmenter.sv
module pon_up_segmenter
    import pon_seg_pkg::*;
#(
    parameter int SEG_BYTES = 268,
    parameter int HDR_WORDS = 6,
    parameter logic [15:0] SYNC_WORD = 16'hA55A
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  unit_id,
    input  logic        rx_valid,
    input  logic [3:0]  rx_nibble,
    input  logic        rx_last,
    output logic        rx_ready,
    output logic        tx_valid,
    output logic [15:0] tx_data
);
    localparam int PAY_WORDS = (SEG_BYTES + 1) / 2;
    localparam int PKT_WORDS = HDR_WORDS + PAY_WORDS;
    localparam int CNT_W     = $clog2(SEG_BYTES + 1);
    localparam int IDX_W     = $clog2(PKT_WORDS);
    localparam int AW        = $clog2(SEG_BYTES + 1);

    typedef struct packed {
        seg_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] widx;
        logic             eof;
        logic [CNT_W-1:0] len;
        logic [7:0]       id;
    } seg_regs_t;

    seg_regs_t s_q, s_d;

    logic          acc, byte_vld, byte_last, wr_en;
    logic [7:0]    byte_dat, pay_hi, pay_lo;
    logic [AW-1:0] rd_addr;

    assign rx_ready = (s_q.state == ST_FILL);
    assign tx_valid = (s_q.state == ST_SEND);
    assign acc      = rx_valid && rx_ready;

    pon_nib_pack u_pack (
        .clk(clk), .rst_n(rst_n), .acc(acc), .nib(rx_nibble), .nib_last(rx_last),
        .byte_vld(byte_vld), .byte_dat(byte_dat), .byte_last(byte_last)
    );

    assign wr_en   = byte_vld && (s_q.state == ST_FILL);
    assign rd_addr = AW'(2 * (int'(s_q.widx) - HDR_WORDS));

    pon_seg_store #(.DEPTH(SEG_BYTES), .AW(AW)) u_store (
        .clk(clk), .wr_en(wr_en), .wr_addr(AW'(s_q.cnt)), .wr_data(byte_dat),
        .rd_addr(rd_addr), .rd_hi(pay_hi), .rd_lo(pay_lo)
    );

    pon_pkt_word #(.HDR_WORDS(HDR_WORDS), .IDX_W(IDX_W), .LEN_W(CNT_W),
                   .SYNC_WORD(SYNC_WORD)) u_word (
        .widx(s_q.widx), .id(s_q.id), .eof(s_q.eof), .len(s_q.len),
        .pay_hi(pay_hi), .pay_lo(pay_lo), .word(tx_data)
    );

    always_comb begin
        s_d = s_q;
        case (s_q.state)
            ST_FILL: begin
                if (wr_en) begin
                    s_d.cnt = s_q.cnt + 1'b1;
                    if (byte_last || (int'(s_q.cnt) + 1 == SEG_BYTES)) begin
                        s_d.state = ST_SEND;
                        s_d.widx  = '0;
                        s_d.eof   = byte_last;
                        s_d.len   = s_q.cnt + 1'b1;
                        s_d.id    = unit_id;
                        s_d.cnt   = '0;
                    end
                end
            end
            ST_SEND: begin
                s_d.widx = s_q.widx + 1'b1;
                if (int'(s_q.widx) == PKT_WORDS - 1) begin
                    s_d.state = ST_FILL;
                    s_d.widx  = '0;
                end
            end
            default: s_d.state = ST_FILL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{state: ST_FILL, default: '0};
        else        s_q <= s_d;
    end

    // R8: input is held off whenever a packet word is on the output
    a_r8_no_accept_while_send: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !rx_ready);
    // R3: a packet runs without gaps until its final word
    a_r3_packet_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && int'(s_q.widx) != PKT_WORDS - 1) |=> tx_valid);
    // R4: the length field never exceeds one segment and is never zero
    a_r4_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (s_q.len != '0 && int'(s_q.len) <= SEG_BYTES));
    // R5: a short segment must be the final one of its frame
    a_r5_short_is_final: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && int'(s_q.len) < SEG_BYTES) |-> s_q.eof);
    // R3: the header sync word opens every packet
    a_r3_sync_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> (tx_data == SYNC_WORD));
    // R10: the header identity stays fixed for the whole packet
    a_r10_id_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && $past(tx_valid)) |-> $stable(s_q.id));
endmodule

// File: tb/pon_up_segmenter_bench.sv
module pon_up_segmenter_bench;
    localparam int SEG = 268;
    localparam int PKT = 140;
    localparam int CAP = 2048;
    localparam int NV  = 9;
    localparam int V_NIB [NV]  = '{2, 3, 6, 200, 534, 536, 538, 1072, 1201};
    localparam int V_SEED[NV]  = '{1, 2, 3, 4, 5, 6, 7, 8, 9};
    localparam logic [7:0] V_ID[NV] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55,
                                        8'h66, 8'h77, 8'h88, 8'h99};

    logic clk = 0, rst_n = 0;
    logic [7:0] unit_id = 8'h00;
    logic rx_valid = 0, rx_last = 0;
    logic [3:0] rx_nibble = 4'h0;
    logic rx_ready, tx_valid;
    logic [15:0] tx_data;

    int checks = 0, failures = 0, ncap = 0, overlap = 0, cycles = 0;
    logic [15:0] cap [CAP];

    always #4 clk = ~clk;

    pon_up_segmenter u_pon_up_segmenter (
        .clk(clk), .rst_n(rst_n), .unit_id(unit_id), .rx_valid(rx_valid),
        .rx_nibble(rx_nibble), .rx_last(rx_last), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data)
    );

    always @(negedge clk) begin
        if (rst_n && tx_valid) begin
            if (ncap < CAP) cap[ncap] = tx_data;
            ncap++;
            if (rx_ready) overlap++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 37 + i * 13 + 5) & 255);
    endfunction

    // expected byte j of a frame of nn nibbles: ends on a low nibble -> upper half zero (R7)
    function automatic logic [7:0] exp_byte(input int seed, input int nn, input int j);
        logic [7:0] b = pat(seed, j);
        if (2 * j + 1 < nn) return b;
        return {4'h0, b[3:0]};
    endfunction

    task automatic send_frame(input int nn, input int seed);
        int k = 0;
        while (k < nn) begin
            @(negedge clk);
            if (rx_ready) begin
                logic [7:0] b = pat(seed, k / 2);
                rx_valid  = 1;
                rx_nibble = (k % 2 == 0) ? b[3:0] : b[7:4];
                rx_last   = (k == nn - 1);
                k++;
            end else begin
                rx_valid = 1; rx_nibble = 4'hF; rx_last = 1;  // ignored garbage (R8)
            end
        end
        @(negedge clk);
        rx_valid = 0; rx_last = 0;
        repeat (PKT + 10) @(negedge clk);
    endtask

    task automatic check_frame(input int nn, input int seed, input logic [7:0] id);
        int nb = (nn + 1) / 2;
        int np = (nb + SEG - 1) / SEG;
        int bad_rsv, bad_pay, first_w, first_a, first_e;
        check(ncap == np * PKT, "R4 word count", ncap, np * PKT);
        if (ncap != np * PKT) return;
        for (int p = 0; p < np; p++) begin
            int base = p * PKT;
            int len  = (nb - p * SEG > SEG) ? SEG : nb - p * SEG;
            logic eof = (p == np - 1);
            check(cap[base] == 16'hA55A, "R3 sync", int'(cap[base]), 16'hA55A);
            check(cap[base + 1] == {id, 7'b0, eof}, "R5/R10 id+flags",
                  int'(cap[base + 1]), int'({id, 7'b0, eof}));
            check(int'(cap[base + 2]) == len, "R4/R6 length", int'(cap[base + 2]), len);
            bad_rsv = 0;
            for (int w = 3; w < 6; w++) if (cap[base + w] != 0) bad_rsv++;
            check(bad_rsv == 0, "R3 reserved zero", bad_rsv, 0);
            bad_pay = 0; first_w = -1; first_a = 0; first_e = 0;
            for (int w = 0; w < PKT - 6; w++) begin
                int j = p * SEG + 2 * w;
                logic [7:0] hi = (2 * w < len) ? exp_byte(seed, nn, j) : 8'h00;
                logic [7:0] lo = (2 * w + 1 < len) ? exp_byte(seed, nn, j + 1) : 8'h00;
                if (cap[base + 6 + w] != {hi, lo}) begin
                    if (first_w < 0) begin
                        first_w = w; first_a = int'(cap[base + 6 + w]); first_e = int'({hi, lo});
                    end
                    bad_pay++;
                end
            end
            check(bad_pay == 0, "R2/R6/R7 payload", first_a, first_e);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(rx_ready == 1 && tx_valid == 0, "R1 reset state", {rx_ready, tx_valid}, 2'b10);
        rst_n = 1;
        @(negedge clk);
        check(rx_ready == 1 && tx_valid == 0, "R1 idle after reset", {rx_ready, tx_valid}, 2'b10);
        for (int v = 0; v < NV; v++) begin
            ncap = 0;
            unit_id = V_ID[v];
            send_frame(V_NIB[v], V_SEED[v]);
            check_frame(V_NIB[v], V_SEED[v], V_ID[v]);
        end
        // R9: exactly one full segment is one final packet
        ncap = 0; unit_id = 8'hC3;
        send_frame(536, 21);
        check(ncap == PKT, "R9 single packet", ncap, PKT);
        check(cap[2] == 16'd268 && cap[1] == 16'hC301, "R9 len+eof",
              int'({cap[1], cap[2]}), int'({16'hC301, 16'd268}));
        // R10: id changed mid-frame, header takes the value at segment close
        ncap = 0; unit_id = 8'h01;
        fork
            send_frame(538, 22);
            begin repeat (100) @(negedge clk); unit_id = 8'h5A; end
        join
        check(cap[1] == 16'h5A00, "R10 id sampled at close", int'(cap[1]), 16'h5A00);
        check(overlap == 0, "R8 ready low while sending", overlap, 0);
        // R1: reset in the middle of a packet
        ncap = 0;
        fork
            begin
                int k = 0;
                while (k < 536) begin
                    @(negedge clk);
                    rx_valid = 1; rx_nibble = 4'h3; rx_last = 0;
                    if (rx_ready) k++;
                end
            end
        join
        @(negedge clk); rx_valid = 0;
        repeat (20) @(negedge clk);
        check(tx_valid == 1, "R8 packet in progress", tx_valid, 1);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        check(rx_ready == 1 && tx_valid == 0, "R1 reset mid-packet", {rx_ready, tx_valid}, 2'b10);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++; failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule